// File: doc/BRIEF.md
# Address-Pattern Partition Write Protector

This block sits between a host and a static RAM. It divides the RAM into sixteen partitions, selected by the four upper address lines, and can block writes to any of them. The protection map is not reachable through data accesses. It can be changed only by a hidden sequence of bus cycles: twenty consecutive reads whose upper address nibbles match a parameterised unlock pattern. The four reads that follow the pattern carry the new sixteen-bit map, four bits per read.

In normal operation the chip-enable strobe passes to the RAM unchanged and is not handled here. The write-enable strobe passes through the write gate. That gate holds the outgoing write-enable high whenever the current upper address selects a partition whose protection bit is set.

A static enable strap lets a board leave the feature unused. With the strap low, the block ignores bus activity and does not drive its write-enable pin. The strobes are treated as synchronous to the block clock.

Top module: `pwp_partition_guard`

## Requirements
- R1: After reset the protection map reads all zeros, and with the strap high the gated write-enable output equals the write-enable input at every address.
- R2: A bus cycle begins on a sampled high-to-low change of `ce_n` and ends on the next sampled low-to-high change. The address is captured at the start of the cycle. The cycle is a write if `we_n` is sampled low in any clock of the cycle, even if it is low for only one clock in the middle; otherwise it is a read.
- R3: The map can be reloaded only after twenty consecutive read cycles. Read number i (counting from 0) must carry `UNLOCK_PAT[4i+3:4i]` on `addr`.
- R4: A write cycle sends the sequencer back to step 0, whether it arrives during the matching reads or during the load reads. Map nibbles already loaded are kept.
- R5: A read that does not match the expected entry sends the matcher back to step 0. That same read is then compared with entry 0; if it equals entry 0, the read counts as the first step.
- R6: The k-th read after a complete match (k = 0..3) writes map bit 4k+j from `addr[j]`. After the fourth such read the sequencer returns to matching at step 0.
- R7: With the strap high, `wr_n_o` is 1 whenever bit `addr` of the map is 1. Otherwise `wr_n_o` equals `we_n`, with no clock of delay.
- R8: With the strap low, `wr_oe_o` is 0 and `wr_n_o` is 1. Bus cycles are ignored: the map does not change and the sequencer is held at step 0.
- R9: The map changes only on the clock edge that samples the end of a read cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en | input | 1 | Static enable strap; low bypasses the block |
| ce_n | input | 1 | Active-low chip enable from the host |
| we_n | input | 1 | Active-low write enable from the host |
| addr | input | 4 | Upper four address lines |
| wr_n_o | output | 1 | Gated active-low write enable to the RAM |
| wr_oe_o | output | 1 | Output enable for the `wr_n_o` pad; low means high impedance |
| prot_map | output | 16 | Protection map, bit p covers partition p |

## Verification
The assertions check three things on every cycle. First, the write gate: a protected address always yields a high output, and an unprotected one passes `we_n` straight through. Second, the bypass behaviour when the strap is low. Third, that the map stays stable except on a read-cycle end.

Some behaviour is sequential and only the bench scenarios can show it:
- the exact unlock order;
- the abort on a write, including a write pulse that appears only mid-cycle;
- the re-check of a mismatching read against entry 0;
- the nibble-to-partition mapping;
- the return to matching after the fourth load read.

// File: rtl/pwp_pkg.sv
`timescale 1ns/1ps
package pwp_pkg;
  localparam int ADDR_W = 4;
  localparam int PART_N = 1 << ADDR_W;
  localparam int LOAD_N = PART_N / ADDR_W;

  typedef enum logic {
    PH_MATCH = 1'b0,
    PH_LOAD  = 1'b1
  } phase_e;

  typedef struct packed {
    logic              done;
    logic              is_wr;
    logic [ADDR_W-1:0] addr;
  } bus_cyc_t;
endpackage

// File: rtl/pwp_cycle_track.sv
`timescale 1ns/1ps
module pwp_cycle_track
  import pwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output bus_cyc_t          cyc_o
);
  logic              ce_q;
  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q;
  logic              ce_fall, ce_rise;

  always_comb begin
    ce_fall = ce_q & ~ce_n_i;
    ce_rise = ~ce_q & ce_n_i & act_q;
    act_d   = act_q;
    wr_d    = wr_q;
    if (ce_fall) begin
      act_d = 1'b1;
      wr_d  = ~we_n_i;
    end else if (act_q && !ce_n_i) begin
      wr_d  = wr_q | ~we_n_i;
    end else if (ce_rise) begin
      act_d = 1'b0;
    end
    cyc_o.done  = ce_rise;
    cyc_o.is_wr = wr_q;
    cyc_o.addr  = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q  <= ce_n_i;
      act_q <= act_d;
      wr_q  <= wr_d;
      if (ce_fall) addr_q <= addr_i;
    end
  end
endmodule

// File: rtl/pwp_unlock_seq.sv
`timescale 1ns/1ps
module pwp_unlock_seq
  import pwp_pkg::*;
#(
  parameter int                          PAT_LEN    = 20,
  parameter logic [PAT_LEN*ADDR_W-1:0]   UNLOCK_PAT = 80'hA5C3_B478_1E2D_96F0_5A3C
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  bus_cyc_t          cyc_i,
  output logic [PART_N-1:0] map_o
);
  localparam int STEP_W = $clog2(PAT_LEN + 1);
  localparam int LD_W   = (LOAD_N > 1) ? $clog2(LOAD_N) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PAT_LEN - 1);
  localparam logic [LD_W-1:0]   LAST_LD   = LD_W'(LOAD_N - 1);

  phase_e            phase_q, phase_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [LD_W-1:0]   ld_q, ld_d;
  logic [PART_N-1:0] map_q, map_d;
  logic              map_we;
  logic              hit_cur, hit_first;

  function automatic logic [ADDR_W-1:0] pat_at(input logic [STEP_W-1:0] idx);
    return UNLOCK_PAT[idx*ADDR_W +: ADDR_W];
  endfunction

  always_comb begin
    phase_d   = phase_q;
    step_d    = step_q;
    ld_d      = ld_q;
    map_we    = 1'b0;
    hit_cur   = (cyc_i.addr == pat_at(step_q));
    hit_first = (cyc_i.addr == pat_at('0));
    if (!en_i) begin
      phase_d = PH_MATCH;
      step_d  = '0;
      ld_d    = '0;
    end else if (cyc_i.done) begin
      if (cyc_i.is_wr) begin
        phase_d = PH_MATCH;
        step_d  = '0;
        ld_d    = '0;
      end else if (phase_q == PH_MATCH) begin
        if (hit_cur) begin
          if (step_q == LAST_STEP) begin
            phase_d = PH_LOAD;
            step_d  = '0;
            ld_d    = '0;
          end else begin
            step_d = step_q + 1'b1;
          end
        end else begin
          step_d = {{(STEP_W-1){1'b0}}, hit_first};
        end
      end else begin
        map_we = 1'b1;
        ld_d   = ld_q + 1'b1;
        if (ld_q == LAST_LD) phase_d = PH_MATCH;
      end
    end
  end

  always_comb begin
    map_d = map_q;
    map_d[ld_q*ADDR_W +: ADDR_W] = cyc_i.addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_MATCH;
      step_q  <= '0;
      ld_q    <= '0;
      map_q   <= '0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      ld_q    <= ld_d;
      if (map_we) map_q <= map_d;
    end
  end

  assign map_o = map_q;
endmodule

// File: rtl/pwp_wr_gate.sv
`timescale 1ns/1ps
module pwp_wr_gate
  import pwp_pkg::*;
(
  input  logic              en_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PART_N-1:0] map_i,
  output logic              wr_n_o,
  output logic              wr_oe_o
);
  logic [PART_N-1:0] hit;

  for (genvar p = 0; p < PART_N; p++) begin : g_part
    assign hit[p] = map_i[p] && (addr_i == ADDR_W'(p));
  end

  assign wr_n_o  = en_i ? (we_n_i | (|hit)) : 1'b1;
  assign wr_oe_o = en_i;
endmodule

// File: rtl/pwp_partition_guard.sv
`timescale 1ns/1ps
module pwp_partition_guard
  import pwp_pkg::*;
#(
  parameter int                        PAT_LEN    = 20,
  parameter logic [PAT_LEN*ADDR_W-1:0] UNLOCK_PAT = 80'hA5C3_B478_1E2D_96F0_5A3C
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_en,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_n_o,
  output logic              wr_oe_o,
  output logic [PART_N-1:0] prot_map
);
  bus_cyc_t cyc;

  pwp_cycle_track u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n_i (ce_n),
    .we_n_i (we_n),
    .addr_i (addr),
    .cyc_o  (cyc)
  );

  pwp_unlock_seq #(
    .PAT_LEN    (PAT_LEN),
    .UNLOCK_PAT (UNLOCK_PAT)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (strap_en),
    .cyc_i (cyc),
    .map_o (prot_map)
  );

  pwp_wr_gate u_gate (
    .en_i    (strap_en),
    .we_n_i  (we_n),
    .addr_i  (addr),
    .map_i   (prot_map),
    .wr_n_o  (wr_n_o),
    .wr_oe_o (wr_oe_o)
  );
endmodule

// File: rtl/pwp_partition_guard_chk.sv
`timescale 1ns/1ps
module pwp_partition_guard_chk
  import pwp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              strap_en,
  input logic              ce_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_n_o,
  input logic              wr_oe_o,
  input logic [PART_N-1:0] prot_map
);
  assert_block_prot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_en && prot_map[addr]) |-> wr_n_o);

  assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_en && !prot_map[addr]) |-> (wr_n_o == we_n));

  assert_bypass_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |-> (wr_n_o && !wr_oe_o));

  assert_bypass_map_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |=> $stable(prot_map));

  assert_map_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce_n && !$past(ce_n)) |=> $stable(prot_map));
endmodule

bind pwp_partition_guard pwp_partition_guard_chk u_chk (.*);

// File: tb/pwp_partition_guard_test.sv
`timescale 1ns/1ps
module pwp_partition_guard_test;
  localparam logic [79:0] TB_PAT = 80'hA5C3_B478_1E2D_96F0_5A3C;

  // {expected wr_n_o with we_n low, address}; valid for map 16'h8025
  localparam logic [4:0] WVEC [16] = '{
    5'b1_0000, 5'b0_0001, 5'b1_0010, 5'b0_0011,
    5'b0_0100, 5'b1_0101, 5'b0_0110, 5'b0_0111,
    5'b0_1000, 5'b0_1001, 5'b0_1010, 5'b0_1011,
    5'b0_1100, 5'b0_1101, 5'b0_1110, 5'b1_1111
  };

  logic        clk = 1'b0;
  logic        rst_n, strap_en, ce_n, we_n;
  logic [3:0]  addr;
  logic        wr_n_o, wr_oe_o;
  logic [15:0] prot_map;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwp_partition_guard #(.PAT_LEN(20), .UNLOCK_PAT(TB_PAT)) uut (
    .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .wr_n_o(wr_n_o), .wr_oe_o(wr_oe_o), .prot_map(prot_map)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); addr = a; ce_n = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic exp, input string req);
    @(negedge clk); addr = a; ce_n = 1'b0; we_n = 1'b0;
    #1 check(req, {15'd0, wr_n_o}, {15'd0, exp});
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock(input int first, input int last);
    for (int i = first; i <= last; i++) rd(TB_PAT[i*4 +: 4]);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strap_en = 1'b1; ce_n = 1'b1; we_n = 1'b1; addr = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 map", prot_map, 16'h0000);
    check("R1 oe", {15'd0, wr_oe_o}, 16'h0001);
    wr(4'h5, 1'b0, "R7 unprotected write passes");

    // full program: map 16'h8025
    unlock(0, 19);
    rd(4'b0101);
    check("R6 nibble0", prot_map, 16'h0005);
    rd(4'b0010);
    check("R6 nibble1", prot_map, 16'h0025);
    rd(4'b0000);
    @(negedge clk); addr = 4'b1000; ce_n = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    check("R9 hold before cycle end", prot_map, 16'h0025);
    @(negedge clk);
    check("R6 R3 final map", prot_map, 16'h8025);

    for (int v = 0; v < 16; v++)
      wr(WVEC[v][3:0], WVEC[v][4], "R7 table");

    // sequencer is back to matching: second program
    unlock(0, 19);
    rd(4'hF); rd(4'h0); rd(4'h0); rd(4'h0);
    check("R6 reprogram", prot_map, 16'h000F);

    // abort by a write whose we_n pulses only mid-cycle (R2, R4)
    unlock(0, 9);
    @(negedge clk); addr = 4'h3; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    unlock(10, 19);
    rd(4'h0); rd(4'h0); rd(4'h0); rd(4'h0);
    check("R2 R4 abort mid-match", prot_map, 16'h000F);

    // abort during load phase keeps the loaded nibble
    unlock(0, 19);
    rd(4'h1);
    wr(4'h7, 1'b0, "R7 write during load");
    rd(4'hF);
    check("R4 abort during load", prot_map, 16'h0001);

    // mismatch re-checked against entry 0 (R5)
    unlock(0, 4);
    rd(TB_PAT[3:0]);
    unlock(1, 19);
    rd(4'h2); rd(4'h0); rd(4'h0); rd(4'h0);
    check("R5 restart on entry 0", prot_map, 16'h0002);

    // strap low: bypass and ignore (R8)
    @(negedge clk); strap_en = 1'b0; addr = 4'h0; we_n = 1'b0;
    #1 check("R8 oe low", {15'd0, wr_oe_o}, 16'h0000);
    check("R8 wr high", {15'd0, wr_n_o}, 16'h0001);
    @(negedge clk); we_n = 1'b1;
    unlock(0, 19);
    rd(4'hF); rd(4'hF); rd(4'hF); rd(4'hF);
    check("R8 map unchanged", prot_map, 16'h0002);
    @(negedge clk); strap_en = 1'b1;
    wr(4'h1, 1'b1, "R8 R7 protection kept");
    wr(4'h0, 1'b0, "R8 R7 unprotected after bypass");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule